// File: doc/BRIEF.md
# Stack-Operand ALU

This unit is the execute stage of a 16-bit stack processor. Each operation arrives as one beat carrying an operation code, the two topmost data-stack words (A on top, B directly below) and the current stack depth. It answers with exactly one beat: either a result word with the number of operands it consumed, or an exception with a code and no result. The surrounding stack logic pops the reported count and pushes the result. On an exception it starts its exception sequence instead.

Both edges use valid/ready. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. The requester must hold its fields stable while `in_valid` is high and not yet accepted. A response stays on the outputs, unchanged, until a clock edge sees `out_ready` high. At most one response is held, so throughput is one operation per cycle when the consumer never stalls.

A sticky overflow bit describes the most recent arithmetic operation that completed. Operations that are not arithmetic, and operations that end in an exception, leave it alone.

Top module: `stack_alu`

## Requirements
- R1: Opcode 0x00 returns A+B and opcode 0x01 returns A−B, both modulo 2^16. The overflow bit is set to the carry out for addition and to the borrow (A<B) for subtraction.
- R2: Opcode 0x02 returns the low 16 bits of A*B and sets overflow when the upper 16 bits are non-zero. Opcode 0x03 returns the unsigned quotient A/B and clears overflow.
- R3: Depth must be at least 2 for every two-operand opcode and at least 1 for opcode 0x0B (NOT). If it is not, the response has `out_fault`=1, `out_code`=3, `out_data`=0 and `out_pops`=0.
- R4: Opcode 0x03 or 0x07 with B=0 (and enough operands) responds with `out_fault`=1 and `out_code`=1.
- R5: Opcodes 0x17, 0x18 and 0x19 are unsigned compares that return the word 1 or 0. 0x17 tests A==B, 0x18 tests B<A, and 0x19 tests B>A.
- R6: Opcodes 0x04, 0x05, 0x06 and 0x07 (signed add, subtract, multiply and divide) treat A and B as two's complement. Overflow is set when the true result does not fit in 16 signed bits. Division truncates toward zero, and 0x8000 / 0xFFFF returns 0x8000 with overflow set.
- R7: Opcodes 0x08, 0x09 and 0x0A return A AND B, A OR B and A XOR B. Opcode 0x0B returns NOT A.
- R8: The shift opcodes shift B by the count in A[15:12]. 0x0C (left) and 0x0E (signed left) fill with zeros. 0x0D (right) fills with zeros. 0x0F (signed right) copies the sign bit of B.
- R9: Overflow resets to 0. It changes only when an arithmetic opcode (0x00–0x07) is accepted without an exception.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every response output holds its value. After reset, `out_valid` is 0.
- R11: A successful response reports `out_pops`=2 for two-operand opcodes and 1 for NOT, so a compare changes the depth by −1.
- R12: Any opcode outside 0x00–0x0F and 0x17–0x1B responds with `out_code`=7. The exception priority is unknown opcode, then too few operands, then zero divisor.
- R13: Opcodes 0x1A and 0x1B are signed compares returning 1 when B<A and when B>A respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | W | Top-of-stack word A |
| in_b | input | W | Second word B |
| in_depth | input | DW | Current data-stack depth |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_data | output | W | Result word (0 on exception) |
| out_fault | output | 1 | Response is an exception |
| out_code | output | 3 | Exception code (0 when no exception) |
| out_pops | output | 2 | Operands consumed |
| ovf_flag | output | 1 | Overflow status of the last completed arithmetic operation |

## Verification
The bench targets the following corner cases:
- The wrap points of every arithmetic form: 0xFFFF+1, 3−9, 0x100*0x100, 0x7FFF+1 signed, and the single signed quotient that overflows. A wrong carry or sign test shows up there as a wrong overflow bit.
- Exception priority. A zero divisor with only one operand must report code 3, not code 1. An unknown opcode at depth 0 must report code 7.
- Operand order. Subtract, divide, the compares and the shifts break if A and B are swapped. For example, `less` of B=45 under A=104 would return 0.
- The sign-fill shift and signed compares on operands whose unsigned order is the reverse of their signed order.
- Overflow holding across a bitwise operation.
- A stalled response that must not change while new requests wait.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'h00,
    OP_SUB  = 5'h01,
    OP_MUL  = 5'h02,
    OP_DIV  = 5'h03,
    OP_SADD = 5'h04,
    OP_SSUB = 5'h05,
    OP_SMUL = 5'h06,
    OP_SDIV = 5'h07,
    OP_AND  = 5'h08,
    OP_OR   = 5'h09,
    OP_XOR  = 5'h0A,
    OP_NOT  = 5'h0B,
    OP_SHL  = 5'h0C,
    OP_SHR  = 5'h0D,
    OP_SSHL = 5'h0E,
    OP_SSHR = 5'h0F,
    OP_EQ   = 5'h17,
    OP_LT   = 5'h18,
    OP_GT   = 5'h19,
    OP_SLT  = 5'h1A,
    OP_SGT  = 5'h1B
  } op_e;

  localparam logic [2:0] EXC_NONE    = 3'h0;
  localparam logic [2:0] EXC_DIVZERO = 3'h1;
  localparam logic [2:0] EXC_UNDER   = 3'h3;
  localparam logic [2:0] EXC_BADOP   = 3'h7;

endpackage

// File: rtl/slu_guard.sv
module slu_guard
  import stack_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 5
) (
  input  logic [4:0]    op,
  input  logic [W-1:0]  b,
  input  logic [DW-1:0] depth,
  output logic          fault,
  output logic [2:0]    code,
  output logic [1:0]    need
);
  logic legal;
  logic divides;

  assign legal   = (op <= OP_SSHR) || ((op >= OP_EQ) && (op <= OP_SGT));
  assign need    = (op == OP_NOT) ? 2'd1 : 2'd2;
  assign divides = (op == OP_DIV) || (op == OP_SDIV);

  always_comb begin
    code = EXC_NONE;
    if (!legal)                      code = EXC_BADOP;
    else if (depth < DW'(need))      code = EXC_UNDER;
    else if (divides && (b == '0))   code = EXC_DIVZERO;
    fault = (code != EXC_NONE);
  end
endmodule

// File: rtl/slu_arith.sv
module slu_arith
  import stack_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         is_arith
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0]            sum, diff;
  logic [2*W-1:0]        uprod;
  logic signed [2*W-1:0] sprod;
  logic [W:0]            shi;
  logic [W-1:0]          dsafe, uquot;
  logic signed [W-1:0]   squot;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign diff  = {1'b0, a} - {1'b0, b};
  assign uprod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign sprod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
  assign shi   = sprod[2*W-1:W-1];
  assign dsafe = (b == '0) ? W'(1) : b;
  assign uquot = a / dsafe;
  assign squot = $signed(a) / $signed(dsafe);
  assign is_arith = (op <= OP_SDIV);

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (op)
      OP_ADD:  begin res = sum[W-1:0];  ovf = sum[W];  end
      OP_SUB:  begin res = diff[W-1:0]; ovf = diff[W]; end
      OP_MUL:  begin res = uprod[W-1:0]; ovf = |uprod[2*W-1:W]; end
      OP_DIV:  res = uquot;
      OP_SADD: begin
        res = sum[W-1:0];
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SSUB: begin
        res = diff[W-1:0];
        ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      OP_SMUL: begin
        res = sprod[W-1:0];
        ovf = !((&shi) || !(|shi));
      end
      OP_SDIV: begin
        if ((a == MIN_NEG) && (&b)) begin
          res = MIN_NEG;
          ovf = 1'b1;
        end else begin
          res = squot;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slu_bitop.sv
module slu_bitop
  import stack_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic          fill;
  logic [W-1:0]  rs [0:CW];
  logic [W-1:0]  ls [0:CW];

  assign cnt   = a[W-1 -: CW];
  assign fill  = (op == OP_SSHR) ? b[W-1] : 1'b0;
  assign rs[0] = b;
  assign ls[0] = b;

  for (genvar s = 0; s < CW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign rs[s+1] = cnt[s] ? {{SH{fill}}, rs[s][W-1:SH]} : rs[s];
    assign ls[s+1] = cnt[s] ? {ls[s][W-1-SH:0], {SH{1'b0}}} : ls[s];
  end

  always_comb begin
    case (op)
      OP_AND:           res = a & b;
      OP_OR:            res = a | b;
      OP_XOR:           res = a ^ b;
      OP_NOT:           res = ~a;
      OP_SHL, OP_SSHL:  res = ls[CW];
      OP_SHR, OP_SSHR:  res = rs[CW];
      default:          res = '0;
    endcase
  end
endmodule

// File: rtl/slu_cmp.sv
module slu_cmp
  import stack_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         is_cmp
);
  logic bit_r;

  assign is_cmp = (op >= OP_EQ) && (op <= OP_SGT);

  always_comb begin
    case (op)
      OP_EQ:   bit_r = (a == b);
      OP_LT:   bit_r = (b < a);
      OP_GT:   bit_r = (b > a);
      OP_SLT:  bit_r = ($signed(b) < $signed(a));
      OP_SGT:  bit_r = ($signed(b) > $signed(a));
      default: bit_r = 1'b0;
    endcase
  end

  assign res = {{(W-1){1'b0}}, bit_r};
endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [4:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [DW-1:0] in_depth,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_fault,
  output logic [2:0]    out_code,
  output logic [1:0]    out_pops,
  output logic          ovf_flag
);
  logic         accept;
  logic         g_fault;
  logic [2:0]   g_code;
  logic [1:0]   g_need;
  logic [W-1:0] ar_res, bit_res, cmp_res, sel;
  logic         ar_ovf, is_arith, is_cmp;

  slu_guard #(.W(W), .DW(DW)) u_guard (
    .op(in_op), .b(in_b), .depth(in_depth),
    .fault(g_fault), .code(g_code), .need(g_need)
  );

  slu_arith #(.W(W)) u_arith (
    .op(in_op), .a(in_a), .b(in_b),
    .res(ar_res), .ovf(ar_ovf), .is_arith(is_arith)
  );

  slu_bitop #(.W(W)) u_bitop (
    .op(in_op), .a(in_a), .b(in_b), .res(bit_res)
  );

  slu_cmp #(.W(W)) u_cmp (
    .op(in_op), .a(in_a), .b(in_b), .res(cmp_res), .is_cmp(is_cmp)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (is_arith)    sel = ar_res;
    else if (is_cmp) sel = cmp_res;
    else             sel = bit_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fault <= 1'b0;
      out_code  <= EXC_NONE;
      out_pops  <= 2'd0;
      ovf_flag  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fault <= g_fault;
      out_code  <= g_code;
      out_data  <= g_fault ? '0 : sel;
      out_pops  <= g_fault ? 2'd0 : g_need;
      if (!g_fault && is_arith) ovf_flag <= ar_ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Response held while the consumer stalls
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_fault)
                              && $stable(out_code) && $stable(out_pops));

  // Two-operand add with a short stack must trap as underflow
  p_short_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == OP_ADD) && (in_depth < DW'(2))
      |=> out_valid && out_fault && (out_code == EXC_UNDER));

  // Unsigned compares produce a 0/1 word
  p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((in_op == OP_EQ) || (in_op == OP_LT) || (in_op == OP_GT)) && (in_depth >= DW'(2))
      |=> (out_data[W-1:1] == '0) && !out_fault);

  // Overflow moves only on an accepted arithmetic request
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && (in_op <= OP_SDIV)) |=> $stable(ovf_flag));

  // An exception carries no result and consumes nothing
  p_fault_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> (out_pops == 2'd0) && (out_data == '0) && (out_code != EXC_NONE));

  // Top opcode value is unassigned
  p_badop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 5'h1F) |=> out_fault && (out_code == EXC_BADOP));
endmodule

// File: tb/tb_stack_alu.sv
`timescale 1ns/1ps
module tb_stack_alu;
  localparam int W  = 16;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [4:0]    in_op = '0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic [DW-1:0] in_depth = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_data;
  logic          out_fault;
  logic [2:0]    out_code;
  logic [1:0]    out_pops;
  logic          ovf_flag;

  always #2.5 clk = ~clk;

  stack_alu #(.W(W), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_depth(in_depth),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_fault(out_fault), .out_code(out_code), .out_pops(out_pops),
    .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [15:0] data;
    logic        fault;
    logic [2:0]  code;
    logic [1:0]  pops;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic m_ovf = 1'b0;
  logic stall = 1'b0;
  logic bp_en = 1'b0;
  logic [7:0] lf = 8'h5A;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [4:0] op, input logic [15:0] a,
                                 input logic [15:0] b, input int d, input logic ov);
    exp_t e;
    longint ua, ub, sa, sb, r;
    int need, cnt;
    bit legal;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cnt = int'(a[15:12]);
    e.data = 0; e.fault = 0; e.code = 0; e.pops = 0; e.ovf = ov; e.tag = "";
    legal = (op <= 5'h0F) || (op >= 5'h17 && op <= 5'h1B);
    need  = (op == 5'h0B) ? 1 : 2;
    if (!legal) begin e.fault = 1; e.code = 3'd7; end
    else if (d < need) begin e.fault = 1; e.code = 3'd3; end
    else if ((op == 5'h03 || op == 5'h07) && b == 0) begin e.fault = 1; e.code = 3'd1; end
    else begin
      e.pops = 2'(need);
      case (op)
        5'h00: begin r = ua + ub; e.ovf = (r > 65535); e.data = 16'(r); end
        5'h01: begin r = ua - ub; e.ovf = (ua < ub); e.data = 16'(r); end
        5'h02: begin r = ua * ub; e.ovf = (r > 65535); e.data = 16'(r); end
        5'h03: begin r = ua / ub; e.ovf = 0; e.data = 16'(r); end
        5'h04: begin r = sa + sb; e.ovf = (r > 32767 || r < -32768); e.data = 16'(r); end
        5'h05: begin r = sa - sb; e.ovf = (r > 32767 || r < -32768); e.data = 16'(r); end
        5'h06: begin r = sa * sb; e.ovf = (r > 32767 || r < -32768); e.data = 16'(r); end
        5'h07: begin r = sa / sb; e.ovf = (r > 32767 || r < -32768); e.data = 16'(r); end
        5'h08: e.data = a & b;
        5'h09: e.data = a | b;
        5'h0A: e.data = a ^ b;
        5'h0B: e.data = ~a;
        5'h0C, 5'h0E: e.data = b << cnt;
        5'h0D: e.data = b >> cnt;
        5'h0F: e.data = 16'($signed(b) >>> cnt);
        5'h17: e.data = 16'(a == b);
        5'h18: e.data = 16'(ub < ua);
        5'h19: e.data = 16'(ub > ua);
        5'h1A: e.data = 16'(sb < sa);
        5'h1B: e.data = 16'(sb > sa);
        default: ;
      endcase
    end
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                      input int d, input string tag);
    exp_t e;
    e = model(op, a, b, d, m_ovf);
    e.tag = tag;
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_depth = DW'(d); in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(e);
    m_ovf = e.ovf;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready <= stall ? 1'b0 : (bp_en ? lf[0] : 1'b1);
  end

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected response", longint'(out_data), 0);
        end else begin
          e = q.pop_front();
          chk((out_data == e.data) && (out_fault == e.fault) && (out_code == e.code)
              && (out_pops == e.pops) && (ovf_flag == e.ovf), e.tag,
              $sformatf("data/fault/code/pops/ovf %0h/%0b/%0d/%0d/%0b vs", out_data,
                        out_fault, out_code, out_pops, ovf_flag),
              longint'(out_data),
              longint'(e.data));
          if ((out_data == e.data) && (out_fault == e.fault) && (out_code == e.code)
              && (out_pops == e.pops) && (ovf_flag == e.ovf)) ;
          else $display("  expected fault/code/pops/ovf %0b/%0d/%0d/%0b",
                        e.fault, e.code, e.pops, e.ovf);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : driver
    exp_t e;
    repeat (4) @(negedge clk);
    #2;
    // Reset state: R10 empty output, R9 overflow cleared
    chk(out_valid == 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", longint'(in_ready), 1);
    chk(ovf_flag == 1'b0, "R9", "ovf after reset", longint'(ovf_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1
    send(5'h00, 16'd12, 16'd3, 2, "R1 add");
    send(5'h00, 16'hFFFF, 16'd1, 3, "R1 add carry");
    send(5'h01, 16'd9, 16'd3, 2, "R1 sub");
    send(5'h01, 16'd3, 16'd9, 2, "R1 sub borrow");
    // R2
    send(5'h02, 16'd14, 16'd7, 2, "R2 mul");
    send(5'h02, 16'h0100, 16'h0100, 2, "R2 mul high");
    send(5'h03, 16'd100, 16'd50, 2, "R2 div");
    // R9: bitwise op keeps overflow (now 0), then set it and keep it
    send(5'h00, 16'hFFFF, 16'h0002, 2, "R9 set ovf");
    send(5'h08, 16'd5383, 16'd6032, 2, "R9 R7 and keeps ovf");
    // R7
    send(5'h09, 16'd7338, 16'd1694, 2, "R7 or");
    send(5'h0A, 16'd9323, 16'd6725, 2, "R7 xor");
    send(5'h0B, 16'd4836, 16'd0, 1, "R7 R11 not");
    // R3
    send(5'h00, 16'd4, 16'd0, 1, "R3 add depth1");
    send(5'h0B, 16'd4, 16'd0, 0, "R3 not depth0");
    send(5'h17, 16'd4, 16'd4, 1, "R3 eq depth1");
    // R4 and R12 priority
    send(5'h03, 16'd9, 16'd0, 2, "R4 div zero");
    send(5'h07, 16'd9, 16'd0, 5, "R4 sdiv zero");
    send(5'h03, 16'd9, 16'd0, 1, "R12 under before divzero");
    send(5'h12, 16'd1, 16'd1, 0, "R12 bad opcode");
    send(5'h1F, 16'd1, 16'd1, 3, "R12 bad opcode top");
    // R5 and R11
    send(5'h17, 16'd100, 16'd100, 2, "R5 R11 eq true");
    send(5'h17, 16'd100, 16'd200, 2, "R5 eq false");
    send(5'h18, 16'd104, 16'd45, 2, "R5 lt true");
    send(5'h18, 16'd12, 16'd6700, 2, "R5 lt false");
    send(5'h19, 16'd55, 16'd7864, 2, "R5 gt true");
    send(5'h19, 16'd9996, 16'd23, 2, "R5 gt false");
    // R13
    send(5'h1A, 16'd1, 16'hFFFF, 2, "R13 slt true");
    send(5'h18, 16'd1, 16'hFFFF, 2, "R13 unsigned contrast");
    send(5'h1B, 16'hFFFF, 16'd1, 2, "R13 sgt true");
    // R6
    send(5'h04, 16'h7FFF, 16'd1, 2, "R6 sadd ovf");
    send(5'h04, 16'hFFFE, 16'd1, 2, "R6 sadd");
    send(5'h05, 16'h8000, 16'd1, 2, "R6 ssub ovf");
    send(5'h06, 16'hFFFD, 16'd5, 2, "R6 smul");
    send(5'h06, 16'h4000, 16'd2, 2, "R6 smul ovf");
    send(5'h07, 16'hFFF9, 16'd2, 2, "R6 sdiv trunc");
    send(5'h07, 16'h8000, 16'hFFFF, 2, "R6 sdiv ovf");
    // R8
    send(5'h0F, 16'h2000, 16'h8000, 2, "R8 sshr");
    send(5'h0D, 16'h2000, 16'h8000, 2, "R8 shr");
    send(5'h0C, 16'hF000, 16'h0001, 2, "R8 shl 15");
    send(5'h0E, 16'h3FFF, 16'h00F1, 2, "R8 sshl");
    send(5'h0D, 16'h0FFF, 16'h1234, 2, "R8 zero count");
    drain();

    // R10 stall: response must persist, input must be refused
    stall = 1'b1;
    repeat (2) @(negedge clk);
    e = model(5'h00, 16'd40, 16'd2, 2, m_ovf);
    send(5'h00, 16'd40, 16'd2, 2, "R10 stalled add");
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b1, "R10", "valid held in stall", longint'(out_valid), 1);
    chk(in_ready == 1'b0, "R10", "in_ready low in stall", longint'(in_ready), 0);
    chk(out_data == e.data, "R10", "data held in stall", longint'(out_data), longint'(e.data));
    stall = 1'b0;
    drain();

    // Back-pressure with a mixed stream
    bp_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [4:0] op;
      op = (i % 3 == 0) ? 5'h18 : ((i % 3 == 1) ? 5'h01 : 5'h0F);
      send(op, 16'(i * 1237 + 5), 16'(i * 419 + 17), 2, "R10 backpressure stream");
    end
    bp_en = 1'b0;
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule